// File: doc/BRIEF.md
# Multiplexed GPIO and LED controller

This block manages three general-purpose pins. Each pin can either carry an LED status signal, which arrives from elsewhere, or work as a software-controlled GPIO. A 32-bit configuration register picks the role of each pin, the drive style of its output buffer and the polarity of its interrupt. A companion register holds the GPIO output data and direction bits and shows the synchronised pin levels. Two more registers hold the sticky interrupt status bits and their enables. The pad is described as an output value plus an output-enable, so the top level only has to place the tri-state buffer.

A GPIO output is either push-pull or open-drain. In open-drain style the pad is driven low for a 0 and released for a 1. Every pin input passes through a two-flop synchroniser and then through a qualification counter. The counter only accepts a level that stays at the selected active polarity for a minimum number of consecutive clock cycles. At a 25 MHz core clock, three cycles meet an 80 ns minimum. A qualified level sets that pin's status bit. Writing 1 to a status bit clears it. The single interrupt line is the registered OR, across all pins, of each status bit ANDed with its enable.

The host port is a plain register port. A write takes effect at the clock edge where `reg_wr` is high. A read returns data on `reg_rdata` one cycle after `reg_rd` is high.

Top module: `gpio_led_mux`

## Requirements
- R1: After reset the configuration, data-out, direction, status and enable registers read 0, every `pin_oe` bit is 0 and `irq` is 0.
- R2: The configuration register is at address 0. LED enables sit at bits 30:28, interrupt polarity at 26:24, a plain storage field at 22:20 and buffer type at 18:16, with pin i at the lowest bit of each field plus i. The other bits read 0 and ignore writes, so writing 0xFFFFFFFF reads back 0x77770000.
- R3: When LED enable bit 28+i is 1, pin i is an output carrying `led_in[i]`, whatever its direction bit holds.
- R4: When buffer-type bit 16+i is 1 (push-pull), an output pin has `pin_oe[i]`=1 and `pin_out[i]` equal to its value.
- R5: When buffer-type bit 16+i is 0 (open-drain), an output pin drives `pin_out[i]`=0 with `pin_oe[i]`=1 for a value of 0, and has `pin_oe[i]`=0 for a value of 1.
- R6: The companion register is at address 1, with data-out in bits 2:0 and direction in bits 10:8 (1 = output). A GPIO pin with direction 0 has `pin_oe[i]`=0. A GPIO pin with direction 1 drives data-out bit i.
- R7: Polarity bit 24+i set to 1 makes a high input level the active condition for pin i. Set to 0, it makes a low level active.
- R8: Status bit i (address 2, bit i) sets only after the synchronised input of a GPIO-mode pin has been active for 3 consecutive cycles. A 2-cycle pulse leaves it clear. An LED-mode pin never sets it.
- R9: Status bits stay set until 1 is written to them at address 2. If the condition is still qualified, the bit sets again on the following clock.
- R10: `irq` is the OR over i of status bit i AND enable bit i (address 3, bits 2:0). It changes one cycle after the status or enable change.
- R11: Address 1 bits 18:16 read the pin levels after the two-flop synchroniser. Bits 31:19, 15:11 and 7:3 read 0.
- R12: `pin_out` and `pin_oe` are registered. They change one cycle after the register write or `led_in` change that causes the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 config, 1 GPIO control, 2 status, 3 enable |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| led_in | input | NPINS | LED activity signals from the rest of the chip |
| pin_in | input | NPINS | Pad input levels (asynchronous) |
| pin_out | output | NPINS | Pad output value |
| pin_oe | output | NPINS | Pad output enable (1 = drive) |
| irq | output | 1 | Combined interrupt request |

## Verification
On every cycle, the assertions check the following. An open-drain pin never drives high. An LED push-pull pin always drives. A GPIO pin set as an input stays released. A status bit rises only after a qualified level. A write-1 clear drops the bit. `irq` tracks status AND enable with one cycle of delay. The bench scenarios cover what needs specific stimulus: the 2-cycle versus 3-cycle pulse boundary of the filter, both polarities, re-setting of a bit whose condition is still present, the masking of reserved bits, and the synchroniser latency seen through readback.

// File: rtl/gpio_led_pkg.sv
package gpio_led_pkg;
  localparam int DATA_W      = 32;
  localparam int FIELD_W     = 3;
  localparam int CFG_LED_LSB = 28;
  localparam int CFG_POL_LSB = 24;
  localparam int CFG_AUX_LSB = 20;
  localparam int CFG_BUF_LSB = 16;
  localparam int IO_DOUT_LSB = 0;
  localparam int IO_DIR_LSB  = 8;
  localparam int IO_PIN_LSB  = 16;

  typedef enum logic [1:0] {
    RA_CFG = 2'd0,
    RA_IO  = 2'd1,
    RA_STS = 2'd2,
    RA_EN  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/gpio_led_infilt.sv
module gpio_led_infilt #(
  parameter int FILT_CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_async,
  input  logic pol_high,
  output logic lvl_sync,
  output logic qual
);
  localparam int CNT_W = $clog2(FILT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FILT_CYCLES);

  logic             s1_q, s2_q;
  logic [CNT_W-1:0] run_q;
  logic             active;

  // synchroniser flops carry no reset so they track the pad during reset
  always_ff @(posedge clk) begin
    s1_q <= pin_async;
    s2_q <= s1_q;
  end

  assign active = (s2_q == pol_high);

  always_ff @(posedge clk) begin
    if (rst)
      run_q <= '0;
    else if (!active)
      run_q <= '0;
    else if (run_q != CNT_MAX)
      run_q <= run_q + 1'b1;
  end

  assign lvl_sync = s2_q;
  assign qual     = (run_q == CNT_MAX);
endmodule

// File: rtl/gpio_led_pad.sv
module gpio_led_pad (
  input  logic clk,
  input  logic rst,
  input  logic led_mode,
  input  logic push_pull,
  input  logic dir_out,
  input  logic dout,
  input  logic led_val,
  output logic pad_out,
  output logic pad_oe
);
  logic drive, val;

  assign drive = led_mode | dir_out;
  assign val   = led_mode ? led_val : dout;

  always_ff @(posedge clk) begin
    if (rst || !drive) begin
      pad_out <= 1'b0;
      pad_oe  <= 1'b0;
    end else if (push_pull) begin
      pad_out <= val;
      pad_oe  <= 1'b1;
    end else begin
      pad_out <= 1'b0;
      pad_oe  <= ~val;
    end
  end
endmodule

// File: rtl/gpio_led_regs.sv
module gpio_led_regs
  import gpio_led_pkg::*;
#(
  parameter int NPINS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NPINS-1:0]  pin_lvl,
  input  logic [NPINS-1:0]  qual,
  output logic [NPINS-1:0]  led_en,
  output logic [NPINS-1:0]  pol,
  output logic [NPINS-1:0]  buf_pp,
  output logic [NPINS-1:0]  dout,
  output logic [NPINS-1:0]  dir,
  output logic [NPINS-1:0]  sts,
  output logic [NPINS-1:0]  ien,
  output logic              irq
);
  logic [FIELD_W-1:0] aux_q;
  logic [NPINS-1:0]   set_v, clr_v;
  logic [DATA_W-1:0]  rd_mux;
  logic               wr_cfg, wr_io, wr_sts, wr_en;
  logic               unused_wdata;

  assign unused_wdata = ^wdata;
  assign wr_cfg = wr && (addr == RA_CFG);
  assign wr_io  = wr && (addr == RA_IO);
  assign wr_sts = wr && (addr == RA_STS);
  assign wr_en  = wr && (addr == RA_EN);

  always_ff @(posedge clk) begin
    if (rst) begin
      led_en <= '0;
      pol    <= '0;
      buf_pp <= '0;
      aux_q  <= '0;
      dout   <= '0;
      dir    <= '0;
      ien    <= '0;
    end else begin
      if (wr_cfg) begin
        led_en <= wdata[CFG_LED_LSB +: NPINS];
        pol    <= wdata[CFG_POL_LSB +: NPINS];
        buf_pp <= wdata[CFG_BUF_LSB +: NPINS];
        aux_q  <= wdata[CFG_AUX_LSB +: FIELD_W];
      end
      if (wr_io) begin
        dout <= wdata[IO_DOUT_LSB +: NPINS];
        dir  <= wdata[IO_DIR_LSB +: NPINS];
      end
      if (wr_en)
        ien <= wdata[NPINS-1:0];
    end
  end

  // sticky status: a clear wins for one cycle, a persisting cause re-sets next
  assign set_v = qual & ~led_en;
  assign clr_v = wr_sts ? wdata[NPINS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts <= '0;
      irq <= 1'b0;
    end else begin
      sts <= (sts | set_v) & ~clr_v;
      irq <= |(sts & ien);
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (addr)
      RA_CFG: begin
        rd_mux[CFG_LED_LSB +: NPINS]   = led_en;
        rd_mux[CFG_POL_LSB +: NPINS]   = pol;
        rd_mux[CFG_BUF_LSB +: NPINS]   = buf_pp;
        rd_mux[CFG_AUX_LSB +: FIELD_W] = aux_q;
      end
      RA_IO: begin
        rd_mux[IO_DOUT_LSB +: NPINS] = dout;
        rd_mux[IO_DIR_LSB +: NPINS]  = dir;
        rd_mux[IO_PIN_LSB +: NPINS]  = pin_lvl;
      end
      RA_STS:  rd_mux[NPINS-1:0] = sts;
      default: rd_mux[NPINS-1:0] = ien;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd)
      rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_led_mux.sv
module gpio_led_mux
  import gpio_led_pkg::*;
#(
  parameter int NPINS       = 3,
  parameter int FILT_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NPINS-1:0]  led_in,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  logic [NPINS-1:0] led_en, pol, buf_pp, dout, dir, sts, ien, qual, pin_lvl;

  gpio_led_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .pin_lvl(pin_lvl), .qual(qual),
    .led_en(led_en), .pol(pol), .buf_pp(buf_pp), .dout(dout), .dir(dir),
    .sts(sts), .ien(ien), .irq(irq)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    gpio_led_infilt #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
      .clk(clk), .rst(rst), .pin_async(pin_in[i]), .pol_high(pol[i]),
      .lvl_sync(pin_lvl[i]), .qual(qual[i])
    );
    gpio_led_pad u_pad (
      .clk(clk), .rst(rst), .led_mode(led_en[i]), .push_pull(buf_pp[i]),
      .dir_out(dir[i]), .dout(dout[i]), .led_val(led_in[i]),
      .pad_out(pin_out[i]), .pad_oe(pin_oe[i])
    );
  end
endmodule

// File: rtl/gpio_led_mux_chk.sv
module gpio_led_mux_chk #(
  parameter int NPINS = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] pin_oe,
  input logic             irq,
  input logic [NPINS-1:0] led_en,
  input logic [NPINS-1:0] buf_pp,
  input logic [NPINS-1:0] dir,
  input logic [NPINS-1:0] sts,
  input logic [NPINS-1:0] ien,
  input logic [NPINS-1:0] qual
);
  logic unused_chk;
  assign unused_chk = ^reg_wdata;

  assert_irq_track_R10: assert property (@(posedge clk) disable iff (rst)
    irq == $past(|(sts & ien)));

  for (genvar i = 0; i < NPINS; i++) begin : g_chk
    assert_od_no_high_R5: assert property (@(posedge clk) disable iff (rst)
      !buf_pp[i] |=> (!pin_oe[i] || !pin_out[i]));

    assert_led_drives_R3: assert property (@(posedge clk) disable iff (rst)
      (led_en[i] && buf_pp[i]) |=> pin_oe[i]);

    assert_input_released_R6: assert property (@(posedge clk) disable iff (rst)
      (!led_en[i] && !dir[i]) |=> !pin_oe[i]);

    assert_sts_needs_qual_R8: assert property (@(posedge clk) disable iff (rst)
      $rose(sts[i]) |-> $past(qual[i]));

    assert_w1c_R9: assert property (@(posedge clk) disable iff (rst)
      (reg_wr && reg_addr == 2'd2 && reg_wdata[i]) |=> !sts[i]);
  end
endmodule

bind gpio_led_mux gpio_led_mux_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
  .led_en(led_en), .buf_pp(buf_pp), .dir(dir), .sts(sts), .ien(ien),
  .qual(qual)
);

// File: tb/gpio_led_mux_tb.sv
`timescale 1ns/1ps
module gpio_led_mux_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [2:0]  led_in = 3'b000;
  logic [2:0]  pin_in = 3'b111;
  logic [2:0]  pin_out, pin_oe;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  gpio_led_mux u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .led_in(led_in), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_low0(input int len);
    @(negedge clk);
    pin_in[0] = 1'b0;
    repeat (len) @(negedge clk);
    pin_in[0] = 1'b1;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(2'd0, d); chk("R1 cfg", d, 32'h0);
    rd(2'd1, d); chk("R1 io dout/dir", d & 32'h0000_0707, 32'h0);
    rd(2'd2, d); chk("R1 sts", d, 32'h0);
    rd(2'd3, d); chk("R1 en", d, 32'h0);
    chk("R1 pin_oe", {29'd0, pin_oe}, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_cfg;
    logic [31:0] d;
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R2 reserved masked", d, 32'h7777_0000);
    wr(2'd0, 32'h0010_0000);
    rd(2'd0, d); chk("R2 storage field", d, 32'h0010_0000);
    wr(2'd0, 32'h0);
    idle(8);
    wr(2'd2, 32'h7);
    rd(2'd2, d); chk("R2 sts cleared", d, 32'h0);
  endtask

  task automatic t_drive;
    wr(2'd0, 32'h0001_0000);           // pin0 push-pull, pins 1,2 open-drain
    wr(2'd1, 32'h0000_0301);           // dir 011, dout 001
    chk("R12 oe before edge", {29'd0, pin_oe}, 32'h0);
    idle(1);
    chk("R4 pin0 pp high", {30'd0, pin_oe[0], pin_out[0]}, 32'h3);
    chk("R5 pin1 od low", {30'd0, pin_oe[1], pin_out[1]}, 32'h2);
    chk("R6 pin2 input", {31'd0, pin_oe[2]}, 32'h0);
    wr(2'd1, 32'h0000_0302);           // dout 010
    idle(1);
    chk("R4 pin0 pp low", {30'd0, pin_oe[0], pin_out[0]}, 32'h2);
    chk("R5 pin1 od release", {31'd0, pin_oe[1]}, 32'h0);
    wr(2'd1, 32'h0);
    idle(1);
    chk("R6 all released", {29'd0, pin_oe}, 32'h0);
  endtask

  task automatic t_led;
    logic [31:0] d;
    wr(2'd0, 32'h4004_0000);           // pin2 LED, push-pull; dir bit 0
    @(negedge clk); led_in[2] = 1'b1;
    chk("R12 led not yet", {31'd0, pin_out[2]}, 32'h0);
    idle(1);
    chk("R3 led pp high", {30'd0, pin_oe[2], pin_out[2]}, 32'h3);
    @(negedge clk); led_in[2] = 1'b0;
    idle(1);
    chk("R3 led pp low", {30'd0, pin_oe[2], pin_out[2]}, 32'h2);
    wr(2'd0, 32'h4000_0000);           // open-drain
    @(negedge clk); led_in[2] = 1'b1;
    idle(1);
    chk("R5 led od release", {31'd0, pin_oe[2]}, 32'h0);
    @(negedge clk); led_in[2] = 1'b0;
    pin_in[2] = 1'b0;                  // active low level on LED pin
    idle(10);
    chk("R5 led od low", {30'd0, pin_oe[2], pin_out[2]}, 32'h2);
    rd(2'd2, d); chk("R8 led pin no status", d, 32'h0);
    pin_in[2] = 1'b1;
    idle(4);
    wr(2'd0, 32'h0);
  endtask

  task automatic t_filter;
    logic [31:0] d;
    pulse_low0(2);
    idle(8);
    rd(2'd2, d); chk("R8 2-cycle pulse ignored", d, 32'h0);
    pulse_low0(3);
    idle(8);
    rd(2'd2, d); chk("R8 3-cycle pulse qualifies R7 low", d, 32'h1);
    wr(2'd2, 32'h1);
    rd(2'd2, d); chk("R9 cleared", d, 32'h0);
  endtask

  task automatic t_pol;
    logic [31:0] d;
    wr(2'd0, 32'h0200_0000);           // pin1 active high, pin high
    idle(8);
    rd(2'd2, d); chk("R7 high polarity", d, 32'h2);
    wr(2'd2, 32'h2);
    rd(2'd2, d); chk("R9 re-set while present", d, 32'h2);
    @(negedge clk); pin_in[1] = 1'b0;
    idle(8);
    rd(2'd2, d); chk("R9 sticky after removal", d, 32'h2);
    wr(2'd2, 32'h2);
    rd(2'd2, d); chk("R9 clear", d, 32'h0);
  endtask

  task automatic t_irq;
    @(negedge clk); pin_in[1] = 1'b1;
    idle(8);
    chk("R10 masked", {31'd0, irq}, 32'h0);
    wr(2'd3, 32'h2);
    chk("R10 one cycle later", {31'd0, irq}, 32'h0);
    idle(1);
    chk("R10 asserted", {31'd0, irq}, 32'h1);
    wr(2'd3, 32'h1);
    idle(2);
    chk("R10 other enable", {31'd0, irq}, 32'h0);
    wr(2'd3, 32'h2);
    idle(2);
    @(negedge clk); pin_in[1] = 1'b0;
    idle(6);
    wr(2'd2, 32'h2);
    idle(2);
    chk("R10 deasserted", {31'd0, irq}, 32'h0);
    wr(2'd0, 32'h0);
    wr(2'd3, 32'h0);
    @(negedge clk); pin_in[1] = 1'b1;
  endtask

  task automatic t_pinread;
    logic [31:0] d;
    idle(4);
    @(negedge clk); pin_in = 3'b101;
    rd(2'd1, d); chk("R11 sync latency", d, 32'h0007_0000);
    idle(3);
    rd(2'd1, d); chk("R11 level readback", d, 32'h0005_0000);
    pin_in = 3'b111;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_cfg();
    t_drive();
    t_led();
    t_filter();
    t_pol();
    t_irq();
    t_pinread();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule